// File: doc/BRIEF.md
# Universal Counter Measurement Sequencer

This block is the control core of a multi-function counter/timer. A prescaler derives a 100 Hz reference tick from the timebase clock. A router sends input A, input B, the timebase or the reference tick to a decimal main counter and to a reference event counter, according to the selected function. The reference counter opens the main counter's count window and closes it after 1, 10, 100 or 1000 of its own events. When the window closes, the sequencer copies the count into display latches with a store pulse, clears the counter with a reset pulse, and stays idle for a fixed gap before it arms the next measurement.

The sequencer handles frequency, period, frequency ratio, time interval, free-running totalize and timebase self-test. It also handles a hold input, an externally timed window and a restart whenever the function or range code changes. A sticky flag records when the most significant decade carries out. The timebase is the block clock. Inputs A and B are synchronous levels whose falling edges are the only events used. All gap and pulse lengths are counted in reference ticks, so the default parameters give real timing and a bench can shrink them.

Top module: `ucount_seq`

## Requirements
- R1: Function code 0 (and the unused codes 6 and 7) is frequency. The result is the number of 1-to-0 transitions of input A in a window of N reference periods. Range code 0, 1, 2 or 3 selects N = 1, 10, 100 or 1000. A reference period is DIV_HI clock cycles, or DIV_LO cycles when sel_1mhz is high.
- R2: Function code 1 is period. The result is the number of clock cycles spanned by N consecutive periods of input A, measured falling edge to falling edge.
- R3: Function code 2 is ratio. The result is the number of input A falling edges during N periods of input B, measured falling edge to falling edge.
- R4: Function code 3 is time interval. The main counter counts clock cycles from each A falling edge up to the next B falling edge. The result is the sum over N such A-then-B intervals. A B edge that comes before any A edge does not end an interval.
- R5: Function code 5 is self-test. The main counter counts clock cycles for N reference periods, which gives N*DIV_HI, or N*DIV_LO with sel_1mhz high.
- R6: Function code 4 is totalize. The main counter counts A falling edges without stopping, and the latches follow it one cycle behind. Hold freezes the latches while counting continues. A range code change has no effect.
- R7: After each measurement, meas_busy is low for GAP_TICKS reference periods. During this gap, store_o is high for the first STORE_TICKS periods. rst_o is high for the next RST_TICKS periods and clears the main counter. store_o and rst_o are never high together.
- R8: Outside totalize, a change of the function or range code during arming or counting ends the measurement. The latches keep their value, an rst_o pulse follows, and a new measurement begins after the gap.
- R9: Outside totalize, hold drops meas_busy, keeps the main counter at zero and leaves the latches unchanged. Releasing hold arms a fresh measurement.
- R10: With ext_range_en high, the window opens on the first reference tick that sees ext_gate high. It closes on the first later reference tick that sees ext_gate low. No measurement completes while ext_gate stays low.
- R11: ovf goes high in the latches when the top decade of the main counter has wrapped from 9 to 0 during the measurement. The digits then show the count modulo 10^DIGITS. The flag clears with the main counter.
- R12: While rst_n is low, the digits and ovf read zero, store_o and rst_o are low, and any measurement is dropped. Digit i is BCD at bits [4i+3:4i], with digit 0 as the least significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fn_sel | input | 3 | Function code |
| range_sel | input | 2 | Range code, N = 10^range_sel |
| sel_1mhz | input | 1 | Use DIV_LO instead of DIV_HI for the reference |
| in_a | input | 1 | Signal input A |
| in_b | input | 1 | Signal input B |
| hold | input | 1 | Hold request |
| ext_range_en | input | 1 | Window timed by ext_gate |
| ext_gate | input | 1 | External window level |
| digits | output | 4*DIGITS | Latched BCD result |
| ovf | output | 1 | Latched overflow flag |
| store_o | output | 1 | Store pulse |
| rst_o | output | 1 | Counter reset pulse |
| meas_busy | output | 1 | Measurement arming or counting |

## Verification
The hardest case to reach is an abort in the middle of a count window. From the ports, the only sign of an open window is meas_busy together with elapsed time. The bench waits for meas_busy to rise, then lets a 100-period window run several hundred cycles into its count before it changes the range code. At that moment it checks that the latches still hold the previous result and that a reset pulse has begun. Totalize continuity under hold and under a range change is tested by sampling the digits at fixed cycle distances, where each step adds a known number of A edges.

// File: rtl/ucount_pkg.sv
package ucount_pkg;

    localparam logic [2:0] FN_FREQ     = 3'd0;
    localparam logic [2:0] FN_PERIOD   = 3'd1;
    localparam logic [2:0] FN_RATIO    = 3'd2;
    localparam logic [2:0] FN_INTERVAL = 3'd3;
    localparam logic [2:0] FN_UNIT     = 3'd4;
    localparam logic [2:0] FN_OSC      = 3'd5;

    typedef enum logic [2:0] {
        S_ARM,
        S_GATE,
        S_STORE,
        S_CLEAR,
        S_WAIT,
        S_HOLD,
        S_UNIT
    } seq_state_e;

    function automatic logic [9:0] range_events(input logic [1:0] r);
        logic [9:0] n;
        unique case (r)
            2'd0: n = 10'd1;
            2'd1: n = 10'd10;
            2'd2: n = 10'd100;
            2'd3: n = 10'd1000;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ucount_prescale.sv
module ucount_prescale #(
    parameter int DIV_HI = 100000,
    parameter int DIV_LO = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_lo,
    output logic tick
);
    localparam int W = $clog2(DIV_HI + 1);
    localparam logic [W-1:0] LIM_HI = W'(DIV_HI - 1);
    localparam logic [W-1:0] LIM_LO = W'(DIV_LO - 1);

    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    assign lim  = sel_lo ? LIM_LO : LIM_HI;
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n || tick) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ucount_route.sv
module ucount_route
    import ucount_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] fn,
    input  logic       in_a,
    input  logic       in_b,
    input  logic       tick,
    input  logic       gate_on,
    output logic       main_evt,
    output logic       ref_evt
);
    logic a_q, b_q, ti_open;
    logic a_fall, b_fall;

    assign a_fall = a_q & ~in_a;
    assign b_fall = b_q & ~in_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q     <= 1'b0;
            b_q     <= 1'b0;
            ti_open <= 1'b0;
        end else begin
            a_q <= in_a;
            b_q <= in_b;
            if (!gate_on || fn != FN_INTERVAL) ti_open <= 1'b0;
            else if (ti_open && b_fall)        ti_open <= 1'b0;
            else if (a_fall)                   ti_open <= 1'b1;
        end
    end

    always_comb begin
        case (fn)
            FN_PERIOD:   begin main_evt = 1'b1;    ref_evt = a_fall;           end
            FN_RATIO:    begin main_evt = a_fall;  ref_evt = b_fall;           end
            FN_INTERVAL: begin main_evt = ti_open; ref_evt = b_fall & ti_open; end
            FN_UNIT:     begin main_evt = a_fall;  ref_evt = 1'b0;             end
            FN_OSC:      begin main_evt = 1'b1;    ref_evt = tick;             end
            default:     begin main_evt = a_fall;  ref_evt = tick;             end
        endcase
    end
endmodule

// File: rtl/ucount_bcd.sv
module ucount_bcd #(
    parameter int DIGITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  en,
    output logic [4*DIGITS-1:0]   value,
    output logic                  ovf
);
    logic [DIGITS:0] carry;

    assign carry[0] = en;

    for (genvar g = 0; g < DIGITS; g++) begin : g_decade
        logic [3:0] d;
        assign carry[g+1]    = carry[g] & (d == 4'd9);
        assign value[4*g+:4] = d;
        always_ff @(posedge clk) begin
            if (!rst_n || clr)  d <= 4'd0;
            else if (carry[g])  d <= (d == 4'd9) ? 4'd0 : d + 4'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr)       ovf <= 1'b0;
        else if (carry[DIGITS])  ovf <= 1'b1;
    end
endmodule

// File: rtl/ucount_fsm.sv
module ucount_fsm
    import ucount_pkg::*;
#(
    parameter int STORE_TICKS = 4,
    parameter int RST_TICKS   = 6,
    parameter int GAP_TICKS   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] fn,
    input  logic [1:0] rng,
    input  logic       hold,
    input  logic       ext_en,
    input  logic       ext_gate,
    input  logic       tick,
    input  logic       ref_evt,
    output seq_state_e state,
    output logic       gate_on,
    output logic       cnt_win,
    output logic       cnt_clr,
    output logic       latch_en,
    output logic       store_o,
    output logic       rst_o,
    output logic       busy
);
    localparam int GW = $clog2(GAP_TICKS + 1);
    localparam logic [GW-1:0] G_STORE = GW'(STORE_TICKS);
    localparam logic [GW-1:0] G_CLEAR = GW'(STORE_TICKS + RST_TICKS);
    localparam logic [GW-1:0] G_GAP   = GW'(GAP_TICKS);

    seq_state_e state_n;
    logic [GW-1:0] gcnt, gcnt_n, g1;
    logic [9:0]    ref_cnt, ref_n;
    logic [2:0]    fn_q;
    logic [1:0]    rng_q;
    logic          abort, hold_stop, start_ev, window_done;

    assign abort     = (fn != fn_q) || ((rng != rng_q) && (fn != FN_UNIT));
    assign hold_stop = hold && (fn != FN_UNIT);
    assign start_ev  = ext_en ? (tick & ext_gate)
                              : ((fn == FN_INTERVAL) ? 1'b1 : ref_evt);
    assign window_done = ext_en ? (tick & ~ext_gate)
                                : (ref_evt && (ref_cnt == range_events(rng) - 10'd1));
    assign g1 = gcnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_ARM;
            gcnt    <= '0;
            ref_cnt <= '0;
            fn_q    <= fn;
            rng_q   <= rng;
        end else begin
            state   <= state_n;
            gcnt    <= gcnt_n;
            ref_cnt <= ref_n;
            fn_q    <= fn;
            rng_q   <= rng;
        end
    end

    always_comb begin
        state_n = state;
        gcnt_n  = gcnt;
        ref_n   = ref_cnt;
        unique case (state)
            S_ARM: begin
                if (abort) begin
                    state_n = S_CLEAR;
                    gcnt_n  = G_STORE;
                end else if (hold_stop) begin
                    state_n = S_HOLD;
                end else if (fn == FN_UNIT) begin
                    state_n = S_UNIT;
                end else if (start_ev) begin
                    state_n = S_GATE;
                    ref_n   = '0;
                end
            end
            S_GATE: begin
                if (abort) begin
                    state_n = S_CLEAR;
                    gcnt_n  = G_STORE;
                end else if (hold_stop) begin
                    state_n = S_HOLD;
                end else if (window_done) begin
                    state_n = S_STORE;
                    gcnt_n  = '0;
                end else if (ref_evt && !ext_en) begin
                    ref_n = ref_cnt + 10'd1;
                end
            end
            S_STORE, S_CLEAR, S_WAIT: begin
                if (tick) begin
                    gcnt_n = g1;
                    if (g1 >= G_GAP)        state_n = S_ARM;
                    else if (g1 >= G_CLEAR) state_n = S_WAIT;
                    else if (g1 >= G_STORE) state_n = S_CLEAR;
                end
            end
            S_HOLD: begin
                if (!hold || fn == FN_UNIT) state_n = S_ARM;
            end
            S_UNIT: begin
                if (abort) begin
                    state_n = S_CLEAR;
                    gcnt_n  = G_STORE;
                end
            end
        endcase
    end

    always_comb begin
        gate_on  = (state == S_GATE);
        cnt_win  = (state == S_GATE) || (state == S_UNIT);
        cnt_clr  = (state == S_CLEAR) || (state == S_HOLD);
        latch_en = (state == S_STORE) || ((state == S_UNIT) && !hold);
        store_o  = (state == S_STORE);
        rst_o    = (state == S_CLEAR);
        busy     = (state == S_ARM) || (state == S_GATE) || (state == S_UNIT);
    end
endmodule

// File: rtl/ucount_seq.sv
module ucount_seq
    import ucount_pkg::*;
#(
    parameter int DIGITS      = 8,
    parameter int DIV_HI      = 100000,
    parameter int DIV_LO      = 10000,
    parameter int STORE_TICKS = 4,
    parameter int RST_TICKS   = 6,
    parameter int GAP_TICKS   = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          fn_sel,
    input  logic [1:0]          range_sel,
    input  logic                sel_1mhz,
    input  logic                in_a,
    input  logic                in_b,
    input  logic                hold,
    input  logic                ext_range_en,
    input  logic                ext_gate,
    output logic [4*DIGITS-1:0] digits,
    output logic                ovf,
    output logic                store_o,
    output logic                rst_o,
    output logic                meas_busy
);
    logic tick, main_evt, ref_evt;
    logic gate_on, cnt_win, cnt_clr, latch_en;
    logic [4*DIGITS-1:0] cnt_value;
    logic cnt_ovf;
    seq_state_e fsm_state;

    ucount_prescale #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel_lo(sel_1mhz), .tick(tick)
    );

    ucount_route u_route (
        .clk(clk), .rst_n(rst_n), .fn(fn_sel), .in_a(in_a), .in_b(in_b),
        .tick(tick), .gate_on(gate_on), .main_evt(main_evt), .ref_evt(ref_evt)
    );

    ucount_fsm #(
        .STORE_TICKS(STORE_TICKS), .RST_TICKS(RST_TICKS), .GAP_TICKS(GAP_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .fn(fn_sel), .rng(range_sel), .hold(hold),
        .ext_en(ext_range_en), .ext_gate(ext_gate), .tick(tick),
        .ref_evt(ref_evt), .state(fsm_state), .gate_on(gate_on),
        .cnt_win(cnt_win), .cnt_clr(cnt_clr), .latch_en(latch_en),
        .store_o(store_o), .rst_o(rst_o), .busy(meas_busy)
    );

    ucount_bcd #(.DIGITS(DIGITS)) u_main (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(main_evt & cnt_win),
        .value(cnt_value), .ovf(cnt_ovf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digits <= '0;
            ovf    <= 1'b0;
        end else if (latch_en) begin
            digits <= cnt_value;
            ovf    <= cnt_ovf;
        end
    end
endmodule

// File: rtl/ucount_seq_chk.sv
module ucount_seq_chk
    import ucount_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input seq_state_e          fsm_state,
    input logic                store_o,
    input logic                rst_o,
    input logic                meas_busy,
    input logic                cnt_win,
    input logic                cnt_ovf,
    input logic [4*DIGITS-1:0] cnt_value,
    input logic [4*DIGITS-1:0] digits
);
    p_store_rst_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_o && rst_o));

    p_busy_off_in_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_o || rst_o) |-> !meas_busy);

    p_reset_follows_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(store_o)) |-> rst_o);

    p_latch_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != S_STORE && fsm_state != S_UNIT) |=> $stable(digits));

    p_ovf_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> !cnt_ovf);

    p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && fsm_state == S_HOLD && $past(fsm_state) == S_HOLD)
            |-> (cnt_value == '0 && !meas_busy));

    p_count_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_win |=> (cnt_value == $past(cnt_value) || cnt_value == '0));
endmodule

bind ucount_seq ucount_seq_chk #(.DIGITS(DIGITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .fsm_state(fsm_state), .store_o(store_o),
    .rst_o(rst_o), .meas_busy(meas_busy), .cnt_win(cnt_win),
    .cnt_ovf(cnt_ovf), .cnt_value(cnt_value), .digits(digits)
);

// File: tb/ucount_seq_tb.sv
module ucount_seq_tb;
    localparam int ND = 3;
    localparam int DH = 20;
    localparam int DL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] fn_sel = 3'd0;
    logic [1:0] range_sel = 2'd0;
    logic sel_1mhz = 1'b0, hold = 1'b0, ext_range_en = 1'b0, ext_gate = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0;
    logic [4*ND-1:0] digits;
    logic ovf, store_o, rst_o, meas_busy;

    int checks = 0, fails = 0;
    int pa = 5, pb = 30, lag = 0;
    int acnt = 0, bcnt = 0;
    logic [63:0] hist = '0;

    always #5 clk = ~clk;

    ucount_seq #(.DIGITS(ND), .DIV_HI(DH), .DIV_LO(DL),
                 .STORE_TICKS(2), .RST_TICKS(2), .GAP_TICKS(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .fn_sel(fn_sel), .range_sel(range_sel),
        .sel_1mhz(sel_1mhz), .in_a(in_a), .in_b(in_b), .hold(hold),
        .ext_range_en(ext_range_en), .ext_gate(ext_gate), .digits(digits),
        .ovf(ovf), .store_o(store_o), .rst_o(rst_o), .meas_busy(meas_busy)
    );

    always @(negedge clk) begin
        acnt = (acnt + 1) % pa;
        bcnt = (bcnt + 1) % pb;
        hist = {hist[62:0], (acnt < pa / 2) ? 1'b1 : 1'b0};
        in_a <= hist[0];
        in_b <= (lag > 0) ? hist[lag] : ((bcnt < pb / 2) ? 1'b1 : 1'b0);
    end

    function automatic logic [4*ND-1:0] to_bcd(input int v);
        logic [4*ND-1:0] r;
        int t;
        t = v;
        for (int i = 0; i < ND; i++) begin
            r[4*i+:4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic int from_bcd(input logic [4*ND-1:0] b);
        int v, m;
        v = 0;
        m = 1;
        for (int i = 0; i < ND; i++) begin
            v = v + int'(b[4*i+:4]) * m;
            m = m * 10;
        end
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_store();
        while (!store_o) @(negedge clk);
        while (store_o) @(negedge clk);
    endtask

    task automatic measure(input string req, input logic [2:0] f,
                           input logic [1:0] r, input int exp, input logic exp_ovf);
        fn_sel = f;
        range_sel = r;
        wait_store();
        wait_store();
        check(req, int'(digits), int'(to_bcd(exp % 1000)));
        check(req, int'(ovf), int'(exp_ovf));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n_low, n_st, n_rs, bad, d1, d2, h1, h2, e1, e2, e3, v;
        cycles(4);
        // R12: values under reset
        check("R12", int'(digits), 0);
        check("R12", int'(ovf), 0);
        check("R12", int'(store_o), 0);
        check("R12", int'(rst_o), 0);
        rst_n = 1'b1;

        // R1: frequency, A period 5
        pa = 5;
        measure("R1", 3'd0, 2'd0, 4, 1'b0);
        measure("R1", 3'd0, 2'd1, 40, 1'b0);
        measure("R1", 3'd0, 2'd2, 400, 1'b0);
        measure("R1", 3'd6, 2'd1, 40, 1'b0);
        pa = 25;
        measure("R1", 3'd0, 2'd3, 800, 1'b0);

        // R2: period
        pa = 7;
        measure("R2", 3'd1, 2'd1, 70, 1'b0);
        measure("R2", 3'd1, 2'd0, 7, 1'b0);

        // R3: ratio
        pa = 3; pb = 30;
        measure("R3", 3'd2, 2'd0, 10, 1'b0);
        measure("R3", 3'd2, 2'd1, 100, 1'b0);

        // R4: time interval, B lags A by 9
        pa = 40; lag = 9;
        measure("R4", 3'd3, 2'd1, 90, 1'b0);
        measure("R4", 3'd3, 2'd0, 9, 1'b0);
        lag = 0;

        // R5: self-test
        measure("R5", 3'd5, 2'd1, 10 * DH, 1'b0);
        sel_1mhz = 1'b1;
        measure("R5", 3'd5, 2'd1, 10 * DL, 1'b0);
        sel_1mhz = 1'b0;

        // R11: overflow and its clearing
        measure("R11", 3'd5, 2'd2, 100 * DH, 1'b1);
        measure("R11", 3'd5, 2'd1, 10 * DH, 1'b0);

        // R7: gap timing in self-test, range 0
        fn_sel = 3'd5; range_sel = 2'd0;
        while (!meas_busy) @(negedge clk);
        while (meas_busy) @(negedge clk);
        n_low = 0; n_st = 0; n_rs = 0; bad = 0;
        while (!meas_busy) begin
            n_low++;
            if (store_o) begin
                n_st++;
                if (n_rs > 0) bad = 1;
            end
            if (rst_o) n_rs++;
            @(negedge clk);
        end
        check("R7", n_low, 6 * DH);
        check("R7", n_st, 2 * DH);
        check("R7", n_rs, 2 * DH);
        check("R7", bad, 0);

        // R8: abort mid-window
        pa = 5;
        measure("R8", 3'd0, 2'd2, 400, 1'b0);
        while (!meas_busy) @(negedge clk);
        cycles(500);
        range_sel = 2'd0;
        cycles(5);
        check("R8", int'(digits), int'(to_bcd(400)));
        check("R8", int'(rst_o), 1);
        wait_store();
        check("R8", int'(digits), int'(to_bcd(4)));

        // R9: hold outside totalize
        measure("R9", 3'd0, 2'd1, 40, 1'b0);
        hold = 1'b1;
        pa = 10;
        cycles(600);
        check("R9", int'(digits), int'(to_bcd(40)));
        check("R9", int'(meas_busy), 0);
        hold = 1'b0;
        wait_store();
        check("R9", int'(digits), int'(to_bcd(20)));

        // R10: external window
        fn_sel = 3'd5; range_sel = 2'd0;
        ext_range_en = 1'b1; ext_gate = 1'b0;
        cycles(400);
        d1 = int'(digits);
        cycles(300);
        check("R10", int'(digits), d1);
        check("R10", int'(meas_busy), 1);
        ext_gate = 1'b1;
        cycles(3 * DH + DH / 2);
        ext_gate = 1'b0;
        wait_store();
        v = from_bcd(digits);
        check("R10", int'(v == 3 * DH || v == 4 * DH), 1);
        ext_range_en = 1'b0;

        // R6: totalize
        pa = 5;
        fn_sel = 3'd4;
        cycles(200);
        d1 = from_bcd(digits);
        cycles(100);
        d2 = from_bcd(digits);
        check("R6", d2 - d1, 20);
        hold = 1'b1;
        cycles(2);
        h1 = from_bcd(digits);
        cycles(60);
        h2 = from_bcd(digits);
        check("R6", h2, h1);
        hold = 1'b0;
        cycles(3);
        e1 = from_bcd(digits);
        check("R6", int'(e1 - h1 >= 12), 1);
        cycles(100);
        e2 = from_bcd(digits);
        check("R6", e2 - e1, 20);
        range_sel = 2'd3;
        cycles(100);
        e3 = from_bcd(digits);
        check("R6", e3 - e2, 20);

        // R12: reset in the middle of a run
        rst_n = 1'b0;
        cycles(2);
        check("R12", int'(digits), 0);
        check("R12", int'(ovf), 0);
        rst_n = 1'b1;
        cycles(5);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule